// File: doc/BRIEF.md
# Flash command interface state machine

This block is the device-side controller of a small flash-style memory. It watches an asynchronous-style parallel bus (active-low chip enable, write enable and output enable), samples it in its own clock domain, and reads multi-cycle command sequences from the writes it sees. Those sequences start timed word program and sector erase operations on an on-chip word array that stands in for flash cells. A shortened two-write program path is available once bypass mode has been entered.

While an operation runs, the host polls either the ready output or the status word returned on any read. Bit 7 of that word holds the complement of the bit 7 value being written, and bit 6 changes on every read. An erase can be paused so the host can read or program other sectors, and then resumed. Writes to protected sectors, and every write while the low-supply flag is high, have no effect. Program and erase durations are set by parameters so that a simulation finishes quickly.

Top module: `flashcmd_ctrl`

## Requirements
- R1: After reset `ready` is 1 and every word reads 0xFFFF.
- R2: The writes 0xAA at word 0x555, 0x55 at 0x2AA and 0xA0 at 0x555, followed by data D at address A, program word A to its old value AND D. Programming never sets a bit.
- R3: While a program or erase runs, `ready` is 0 and a read at any address returns a status word. Its bit 7 is the inverse of bit 7 of the target value (the programmed data, or 1 for erase), and bits 15:8 and 5:0 are 0. Once the operation ends, reads return array data.
- R4: While busy, bit 6 of the status word differs between two consecutive reads. When ready, repeated reads of one word return the same value.
- R5: 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 enters bypass mode. In bypass, 0xA0 at any address followed by data D at A programs A. Any other write in bypass leaves bypass mode.
- R6: A write that does not match the next expected cycle of a sequence returns the decoder to reading array data. Any later program cycle then has no effect.
- R7: The six writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 0x30 at any address of a sector erase that sector. The sector is first pre-programmed one word per cycle, and after the erase time every word of the sector reads 0xFFFF. Other sectors keep their values.
- R8: 0xB0 written during an erase suspends it, and `ready` returns to 1. Reads then return array data. 0x30 resumes the erase, which completes with the sector erased.
- R9: While suspended, a program to a sector other than the one being erased runs normally. A program to the sector being erased has no effect.
- R10: A program or erase aimed at a sector whose `prot_sect` bit is 1 has no effect, and `ready` stays 1.
- R11: While `low_supply` is 1, every write is ignored.
- R12: `dout_en` is 1 only while `ce_n` and `oe_n` are both 0. At all other times `dout` is 0.
- R13: If a suspend arrives in the cycle the erase finishes, the erase completes. In every case a later resume leaves the sector fully erased and the device ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable; a write is taken on its rising edge |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data; the command code is in bits 7:0 |
| dout | output | DATA_W | Read data or status word |
| dout_en | output | 1 | High while a read drives `dout` |
| ready | output | 1 | High when no program or erase is running |
| prot_sect | input | 2**SECT_W | Per-sector protection mask |
| low_supply | input | 1 | Low-supply flag; blocks all writes |

## Verification
A suspend command and the final step of the erase timer can land in the same cycle. When that happens, the finishing erase has priority. The bench provokes this by sweeping the delay between the erase command and the suspend write over a window of cycles that straddles the computed completion edge. After each attempt it writes a resume and waits for ready. It then judges every offset by its outcome: the erased sector reads all ones and the device is idle, whether the suspend was taken or lost to completion.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

  typedef enum logic [2:0] {
    D_READ, D_UL1, D_UL2, D_PGM, D_E1, D_E2, D_E3
  } dec_st_t;

  typedef enum logic [2:0] {
    E_IDLE, E_PROG, E_PRE, E_ERS, E_SUSP, E_SPROG
  } eng_st_t;

  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [7:0]  OP_PROGRAM  = 8'hA0;
  localparam logic [7:0]  OP_ERASE    = 8'h80;
  localparam logic [7:0]  OP_SECTOR   = 8'h30;
  localparam logic [7:0]  OP_BYPASS   = 8'h20;
  localparam logic [7:0]  OP_SUSPEND  = 8'hB0;
  localparam logic [7:0]  OP_RESUME   = 8'h30;
  localparam logic [10:0] KEY_ADDR_1  = 11'h555;
  localparam logic [10:0] KEY_ADDR_2  = 11'h2AA;

endpackage

// File: rtl/flashcmd_decode.sv
module flashcmd_decode
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int SECT_W = 2,
  parameter int WPS_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_ev,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [(1<<SECT_W)-1:0] prot,
  input  logic                   ers_run,
  input  logic                   prog_run,
  input  logic                   susp,
  input  logic [SECT_W-1:0]      ers_sect,
  output logic                   prog_go,
  output logic                   ers_go,
  output logic                   susp_go,
  output logic                   resume_go,
  output logic [SECT_W+WPS_W-1:0] go_addr,
  output logic [DATA_W-1:0]      go_data
);
  localparam int AW = SECT_W + WPS_W;

  dec_st_t st, st_nx;
  logic bypass, byp_nx;
  logic p_go, e_go, s_go, r_go;

  logic [7:0]        cmd;
  logic              key1, key2, at_key1;
  logic [SECT_W-1:0] wr_sect;
  logic              sect_ok;

  assign cmd     = wr_data[7:0];
  assign at_key1 = wr_addr == ADDR_W'(KEY_ADDR_1);
  assign key1    = at_key1 && cmd == KEY_FIRST;
  assign key2    = wr_addr == ADDR_W'(KEY_ADDR_2) && cmd == KEY_SECOND;
  assign wr_sect = wr_addr[WPS_W +: SECT_W];
  assign sect_ok = !prot[wr_sect] && !(susp && wr_sect == ers_sect);

  always_comb begin
    st_nx  = st;
    byp_nx = bypass;
    p_go = 1'b0; e_go = 1'b0; s_go = 1'b0; r_go = 1'b0;
    if (wr_ev) begin
      if (ers_run) begin
        s_go  = cmd == OP_SUSPEND;
        st_nx = D_READ;
      end else if (!prog_run) begin
        st_nx = D_READ;
        case (st)
          D_READ: begin
            if (bypass) begin
              if (cmd == OP_PROGRAM) st_nx = D_PGM;
              else                   byp_nx = 1'b0;
            end else if (key1) begin
              st_nx = D_UL1;
            end else if (susp && cmd == OP_RESUME) begin
              r_go = 1'b1;
            end
          end
          D_UL1: if (key2) st_nx = D_UL2;
          D_UL2: begin
            if (at_key1) begin
              if (cmd == OP_PROGRAM)                st_nx  = D_PGM;
              else if (cmd == OP_ERASE && !susp)    st_nx  = D_E1;
              else if (cmd == OP_BYPASS && !susp)   byp_nx = 1'b1;
            end
          end
          D_PGM: p_go = sect_ok;
          D_E1:  if (key1) st_nx = D_E2;
          D_E2:  if (key2) st_nx = D_E3;
          D_E3:  e_go = cmd == OP_SECTOR && sect_ok;
          default: st_nx = D_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= D_READ;
      bypass <= 1'b0;
      prog_go <= 1'b0; ers_go <= 1'b0; susp_go <= 1'b0; resume_go <= 1'b0;
      go_addr <= '0;
      go_data <= '0;
    end else begin
      st <= st_nx;
      bypass <= byp_nx;
      prog_go <= p_go; ers_go <= e_go; susp_go <= s_go; resume_go <= r_go;
      if (p_go || e_go) begin
        go_addr <= wr_addr[AW-1:0];
        go_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/flashcmd_engine.sv
module flashcmd_engine
  import flashcmd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SECT_W    = 2,
  parameter int WPS_W     = 4,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_go,
  input  logic                    ers_go,
  input  logic                    susp_go,
  input  logic                    resume_go,
  input  logic [SECT_W+WPS_W-1:0] go_addr,
  input  logic [DATA_W-1:0]       go_data,
  input  logic [SECT_W+WPS_W-1:0] rd_addr,
  input  logic                    tog,
  output logic [DATA_W-1:0]       rd_word,
  output logic                    busy,
  output logic                    ers_run,
  output logic                    prog_run,
  output logic                    susp,
  output logic [SECT_W-1:0]       ers_sect
);
  localparam int AW     = SECT_W + WPS_W;
  localparam int NWORDS = 1 << AW;
  localparam int WPS    = 1 << WPS_W;
  localparam int PCNT_W = $clog2(PROG_CYC + 1);
  localparam int ECNT_W = $clog2(ERASE_CYC + 1);

  function automatic logic [DATA_W-1:0] prog_word(input logic [DATA_W-1:0] old,
                                                  input logic [DATA_W-1:0] d);
    return old & d;
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic target_b7,
                                                    input logic t);
    logic [DATA_W-1:0] s;
    s = '0;
    s[7] = ~target_b7;
    s[6] = t;
    return s;
  endfunction

  eng_st_t st;
  logic [DATA_W-1:0] mem [NWORDS];
  logic [AW-1:0]     tgt_a;
  logic [DATA_W-1:0] tgt_d;
  logic [PCNT_W-1:0] pcnt;
  logic [ECNT_W-1:0] ecnt;
  logic [WPS_W-1:0]  pre_idx;
  logic              sus_pre;

  // named internal events
  logic prog_done, ers_done, susp_take;
  logic [DATA_W-1:0] prog_old;

  assign prog_run  = st == E_PROG || st == E_SPROG;
  assign ers_run   = st == E_PRE || st == E_ERS;
  assign busy      = prog_run || ers_run;
  assign susp      = st == E_SUSP || st == E_SPROG;
  assign prog_done = prog_run && pcnt == PCNT_W'(PROG_CYC - 1);
  assign ers_done  = st == E_ERS && ecnt == ECNT_W'(ERASE_CYC - 1);
  assign susp_take = susp_go && (st == E_PRE || (st == E_ERS && !ers_done));
  assign prog_old  = mem[tgt_a];
  assign rd_word   = busy ? status_word(prog_run ? tgt_d[7] : 1'b1, tog) : mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE;
      for (int i = 0; i < NWORDS; i++) mem[i] <= '1;
      tgt_a <= '0; tgt_d <= '0; pcnt <= '0; ecnt <= '0;
      pre_idx <= '0; sus_pre <= 1'b0; ers_sect <= '0;
    end else begin
      case (st)
        E_IDLE, E_SUSP: begin
          if (st == E_SUSP && resume_go) begin
            st <= sus_pre ? E_PRE : E_ERS;
          end else if (prog_go) begin
            tgt_a <= go_addr;
            tgt_d <= go_data;
            pcnt  <= '0;
            st    <= (st == E_SUSP) ? E_SPROG : E_PROG;
          end else if (st == E_IDLE && ers_go) begin
            ers_sect <= go_addr[WPS_W +: SECT_W];
            pre_idx  <= '0;
            st       <= E_PRE;
          end
        end
        E_PROG, E_SPROG: begin
          if (prog_done) begin
            mem[tgt_a] <= prog_word(mem[tgt_a], tgt_d);
            st <= (st == E_SPROG) ? E_SUSP : E_IDLE;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        E_PRE: begin
          if (susp_take) begin
            st <= E_SUSP;
            sus_pre <= 1'b1;
          end else begin
            mem[{ers_sect, pre_idx}] <= '0;
            if (pre_idx == '1) begin
              st   <= E_ERS;
              ecnt <= '0;
            end else begin
              pre_idx <= pre_idx + 1'b1;
            end
          end
        end
        E_ERS: begin
          if (susp_take) begin
            st <= E_SUSP;
            sus_pre <= 1'b0;
          end else if (ers_done) begin
            for (int w = 0; w < WPS; w++) mem[{ers_sect, WPS_W'(w)}] <= '1;
            st <= E_IDLE;
          end else begin
            ecnt <= ecnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (mem[tgt_a] & ~$past(prog_old)) == '0); // R2

  AST_ERASE_FILLS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ers_done |=> (mem[{ers_sect, WPS_W'(0)}] == '1 && mem[{ers_sect, {WPS_W{1'b1}}}] == '1)); // R7

  AST_SUSPEND_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_SUSP && $past(st) != E_SUSP) |->
      ($past(st) == E_PRE || $past(st) == E_ERS || $past(st) == E_SPROG)); // R8

  AST_SUSP_PROG_NOT_ERASE_SECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_SPROG && $past(st) == E_SUSP) |-> tgt_a[WPS_W +: SECT_W] != ers_sect); // R9

endmodule

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int SECT_W    = 2,
  parameter int WPS_W     = 4,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      din,
  output logic [DATA_W-1:0]      dout,
  output logic                   dout_en,
  output logic                   ready,
  input  logic [(1<<SECT_W)-1:0] prot_sect,
  input  logic                   low_supply
);
  localparam int AW = SECT_W + WPS_W;

  logic we_q, oe_q, tog;
  logic wr_ev, rd_start;
  logic prog_go, ers_go, susp_go, resume_go;
  logic [AW-1:0]     go_addr;
  logic [DATA_W-1:0] go_data, rd_word;
  logic busy, ers_run, prog_run, susp;
  logic [SECT_W-1:0] ers_sect;

  assign wr_ev    = !ce_n && we_n && !we_q && !low_supply;
  assign rd_start = !ce_n && !oe_n && oe_q;
  assign dout_en  = !ce_n && !oe_n;
  assign dout     = dout_en ? rd_word : '0;
  assign ready    = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
      tog  <= 1'b0;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
      if (rd_start) tog <= ~tog;
    end
  end

  flashcmd_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W), .WPS_W(WPS_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .wr_addr(addr), .wr_data(din),
    .prot(prot_sect), .ers_run(ers_run), .prog_run(prog_run), .susp(susp),
    .ers_sect(ers_sect), .prog_go(prog_go), .ers_go(ers_go), .susp_go(susp_go),
    .resume_go(resume_go), .go_addr(go_addr), .go_data(go_data)
  );

  flashcmd_engine #(
    .DATA_W(DATA_W), .SECT_W(SECT_W), .WPS_W(WPS_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .ers_go(ers_go),
    .susp_go(susp_go), .resume_go(resume_go), .go_addr(go_addr),
    .go_data(go_data), .rd_addr(addr[AW-1:0]), .tog(tog), .rd_word(rd_word),
    .busy(busy), .ers_run(ers_run), .prog_run(prog_run), .susp(susp),
    .ers_sect(ers_sect)
  );

  AST_LOW_SUPPLY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $past(low_supply) |-> !(prog_go || ers_go || susp_go || resume_go)); // R11

  AST_READ_ENABLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (!dout_en && dout == '0)); // R12

endmodule

// File: tb/flashcmd_ctrl_tb.sv
module flashcmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic dout_en, ready;
  logic [3:0] prot_sect = '0;
  logic low_supply = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] exp;
    logic [15:0] mask;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic [15:0] obs;
  event rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  flashcmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .ready(ready),
    .prot_sect(prot_sect), .low_supply(low_supply)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each completed read
  initial begin
    forever begin
      @(rd_ev);
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard-empty", obs, 16'h0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk((obs & it.mask) == (it.exp & it.mask), it.tag, obs & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic bus_write(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); v = dout;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_expect(input logic [10:0] a, input logic [15:0] e,
                           input logic [15:0] m, input string tag);
    item_t it;
    logic [15:0] v;
    it.exp = e; it.mask = m; it.tag = tag;
    sb_q.push_back(it);
    bus_read(a, v);
    obs = v;
    ->rd_ev;
    #1;
  endtask

  task automatic unlock();
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AA, 16'h0055);
  endtask

  task automatic program_word(input logic [10:0] a, input logic [15:0] d);
    unlock();
    bus_write(11'h555, 16'h00A0);
    bus_write(a, d);
  endtask

  task automatic erase_sector(input logic [10:0] a);
    unlock();
    bus_write(11'h555, 16'h0080);
    unlock();
    bus_write(a, 16'h0030);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (ready) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 16'h0, 16'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] s1, s2;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk(ready == 1'b1, "R1 ready after reset", {15'h0, ready}, 16'h1);
    rd_expect(11'h000, 16'hFFFF, 16'hFFFF, "R1 word 0x00 erased");
    rd_expect(11'h023, 16'hFFFF, 16'hFFFF, "R1 word 0x23 erased");

    // R12 output gating
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    chk(!dout_en && dout == 16'h0, "R12 no drive with oe_n high", dout, 16'h0);
    ce_n = 1'b1;

    // R2 / R3 / R4 normal program
    program_word(11'h003, 16'h1234);
    chk(ready == 1'b0, "R3 ready low while programming", {15'h0, ready}, 16'h0);
    rd_expect(11'h003, 16'h0080, 16'hFFBF, "R3 status bit7 inverted");
    bus_read(11'h003, s1);
    bus_read(11'h003, s2);
    chk(s1[6] != s2[6], "R4 bit6 toggles while busy", s2, s1);
    wait_ready();
    rd_expect(11'h003, 16'h1234, 16'hFFFF, "R2 programmed value");
    rd_expect(11'h003, 16'h1234, 16'hFFFF, "R4 stable when ready");
    program_word(11'h003, 16'hFF0F);
    wait_ready();
    rd_expect(11'h003, 16'h1204, 16'hFFFF, "R2 program only clears bits");

    // R6 broken sequence
    bus_write(11'h555, 16'h00AA);
    bus_write(11'h2AB, 16'h0055);
    bus_write(11'h555, 16'h00A0);
    bus_write(11'h005, 16'h0000);
    idle(30);
    rd_expect(11'h005, 16'hFFFF, 16'hFFFF, "R6 aborted sequence no program");

    // R5 bypass
    unlock();
    bus_write(11'h555, 16'h0020);
    bus_write(11'h000, 16'h00A0);
    bus_write(11'h006, 16'h00F0);
    wait_ready();
    rd_expect(11'h006, 16'h00F0, 16'hFFFF, "R5 bypass two-cycle program");
    bus_write(11'h000, 16'h0000);
    bus_write(11'h000, 16'h00A0);
    bus_write(11'h007, 16'h0000);
    idle(30);
    rd_expect(11'h007, 16'hFFFF, 16'hFFFF, "R5 bypass exited");

    // R10 protection
    prot_sect = 4'b0001;
    erase_sector(11'h000);
    chk(ready == 1'b1, "R10 protected erase stays ready", {15'h0, ready}, 16'h1);
    program_word(11'h004, 16'h0000);
    idle(30);
    rd_expect(11'h003, 16'h1204, 16'hFFFF, "R10 protected erase no effect");
    rd_expect(11'h004, 16'hFFFF, 16'hFFFF, "R10 protected program no effect");
    prot_sect = 4'b0000;

    // R11 low supply
    low_supply = 1'b1;
    program_word(11'h008, 16'h0000);
    idle(30);
    low_supply = 1'b0;
    rd_expect(11'h008, 16'hFFFF, 16'hFFFF, "R11 low supply write ignored");

    // R7 sector erase
    program_word(11'h013, 16'hA5A5);
    wait_ready();
    erase_sector(11'h000);
    idle(8);
    chk(ready == 1'b0, "R7 busy during pre-program", {15'h0, ready}, 16'h0);
    rd_expect(11'h003, 16'h0000, 16'hFFBF, "R3 erase status bit7 zero");
    wait_ready();
    rd_expect(11'h003, 16'hFFFF, 16'hFFFF, "R7 word 0x03 erased");
    rd_expect(11'h006, 16'hFFFF, 16'hFFFF, "R7 word 0x06 erased");
    rd_expect(11'h013, 16'hA5A5, 16'hFFFF, "R7 other sector kept");

    // R8 / R9 suspend and resume
    erase_sector(11'h000);
    idle(2);
    bus_write(11'h000, 16'h00B0);
    chk(ready == 1'b1, "R8 ready while suspended", {15'h0, ready}, 16'h1);
    rd_expect(11'h013, 16'hA5A5, 16'hFFFF, "R8 array read while suspended");
    program_word(11'h031, 16'h0F0F);
    wait_ready();
    rd_expect(11'h031, 16'h0F0F, 16'hFFFF, "R9 program other sector in suspend");
    program_word(11'h00E, 16'h1111);
    idle(30);
    chk(ready == 1'b1, "R9 erasing-sector program rejected", {15'h0, ready}, 16'h1);
    rd_expect(11'h00E, 16'hFFFF, 16'hFFFF, "R9 erasing sector word untouched");
    bus_write(11'h000, 16'h0030);
    idle(2);
    chk(ready == 1'b0, "R8 busy after resume", {15'h0, ready}, 16'h0);
    wait_ready();
    rd_expect(11'h00E, 16'hFFFF, 16'hFFFF, "R8 erase completes after resume");
    rd_expect(11'h000, 16'hFFFF, 16'hFFFF, "R8 first word erased after resume");

    // R13 suspend swept across erase completion
    for (int d = 44; d <= 58; d++) begin
      program_word(11'h035, 16'h0000);
      wait_ready();
      erase_sector(11'h030);
      idle(d);
      bus_write(11'h000, 16'h00B0);
      idle(2);
      bus_write(11'h000, 16'h0030);
      wait_ready();
      chk(ready == 1'b1, "R13 ready after sweep point", {15'h0, ready}, 16'h1);
      rd_expect(11'h035, 16'hFFFF, 16'hFFFF, "R13 sector erased at sweep point");
    end
    rd_expect(11'h031, 16'hFFFF, 16'hFFFF, "R13 whole sector erased");

    idle(2);
    chk(sb_q.size() == 0, "scoreboard drained", 16'(sb_q.size()), 16'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule